// File: doc/BRIEF.md
# Three-Dimensional Transfer Request Sequencer

This block holds one working description of a memory-to-memory transfer and turns each synchronization event into transfer-request descriptors for a downstream data mover. A transfer is organised in three levels. An array is a run of bytes. A frame is a number of arrays. A block is a number of frames. Source and destination each carry their own signed stride for stepping between arrays and between frames. Either side can also be held at one fixed address. Each descriptor carries a source address, a destination address and a byte count. The block does not move data itself.

A synchronization bit selects how much work one event triggers. In array mode an event produces one descriptor. In frame mode an event produces every array of the current frame, back to back. When the last array of the last frame has been accepted, the block pulses a completion output. It can also pulse a chain output that lets a second sequencer start without an external event. It then replaces its working description with one of a few stored descriptions named by a link field, which allows ping-pong buffers and automatic reload. A link to no stored slot leaves the sequencer empty. Events on an empty or badly programmed description are reported as errors, and no request is issued for them.

Descriptors leave on a valid/ready interface. Once `req_valid` is high, the descriptor fields hold steady until `req_ready` is also high on a rising clock edge. Counters and addresses move only on that handshake, so any amount of back-pressure is tolerated without losing or repeating an array.

Top module: `dma3d_seq`

## Requirements
- R1: After reset, `req_valid`, `done_o`, `chain_o` and `err_o` are all low.
- R2: With `cfg_absync`=0 (array mode), one event produces exactly one descriptor. After it is accepted, `req_valid` falls, and within a frame the next array's source address is the previous one plus the sign-extended source array stride (the destination uses its own array stride).
- R3: After the last array of a frame is accepted, the next address on each side is that frame's first address plus the sign-extended frame stride of that side. The array counter reloads and the frame counter decrements.
- R4: With `cfg_absync`=1 (frame mode), one event produces `cfg_bcnt` descriptors back to back. `req_valid` stays high between them and falls after the frame's last one.
- R5: With a side's constant bit set (`cfg_sconst`/`cfg_dconst`), that side's address never changes, whatever strides are programmed.
- R6: Strides are 16-bit two's-complement values, so a negative stride moves the address down.
- R7: While `req_valid` is high and `req_ready` is low, `req_src`, `req_dst` and `req_bytes` hold steady and no counter advances.
- R8: `done_o` is a one-cycle pulse in the cycle after the last descriptor of the block is accepted. `chain_o` pulses in that same cycle when the description's chain bit is set, and stays low otherwise.
- R9: At block completion the working description is reloaded from stored slot `link` (slots 0 to NSETS-1), and the next event starts that slot's transfer from its first array.
- R10: A link value of all ones (or any value of NSETS or more) leaves the sequencer empty. The next event then gives a one-cycle `err_o` pulse in the following cycle and no descriptor.
- R11: If the array, frame or block count is zero, an event gives a one-cycle `err_o` pulse in the following cycle and no descriptor.
- R12: An event that arrives while a descriptor is still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one description this cycle |
| cfg_active | input | 1 | 1: write the working description, 0: write stored slot `cfg_slot` |
| cfg_slot | input | $clog2(NSETS) | Stored slot index |
| cfg_src | input | 32 | First source address |
| cfg_dst | input | 32 | First destination address |
| cfg_acnt | input | 16 | Bytes per array |
| cfg_bcnt | input | 16 | Arrays per frame |
| cfg_ccnt | input | 16 | Frames per block |
| cfg_sbidx | input | 16 | Source array stride (signed) |
| cfg_dbidx | input | 16 | Destination array stride (signed) |
| cfg_scidx | input | 16 | Source frame stride (signed) |
| cfg_dcidx | input | 16 | Destination frame stride (signed) |
| cfg_link | input | 3 | Slot loaded at completion; all ones means none |
| cfg_absync | input | 1 | 0: array per event, 1: frame per event |
| cfg_sconst | input | 1 | Constant source address |
| cfg_dconst | input | 1 | Constant destination address |
| cfg_chain | input | 1 | Pulse `chain_o` at completion |
| evt_i | input | 1 | Synchronization event |
| req_valid | output | 1 | Descriptor valid |
| req_ready | input | 1 | Descriptor accepted by the data mover |
| req_src | output | 32 | Descriptor source address |
| req_dst | output | 32 | Descriptor destination address |
| req_bytes | output | 16 | Descriptor byte count |
| done_o | output | 1 | Block completion pulse |
| chain_o | output | 1 | Chain trigger pulse |
| err_o | output | 1 | Rejected-event pulse |

## Verification
The hardest condition to reach from the ports is a link reload that leads straight into a second transfer in the other synchronization mode, with a different addressing style. This has to happen after a frame boundary with a negative stride, and then be followed by an empty sequencer. The stimulus stores a frame-mode, constant-source slot and then runs an array-mode transfer linked to it. A single table of expected descriptors spans both transfers, so the reload is judged purely by which addresses appear. A second directed sequence holds `req_ready` low and fires a second event while the first is stalled, which shows both the hold rule and the ignored event.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  localparam int AW = 32;   // address width
  localparam int CW = 16;   // counter width
  localparam int IW = 16;   // stride width
  localparam int LW = 3;    // link field width

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [CW-1:0] acnt;
    logic [CW-1:0] bcnt;
    logic [CW-1:0] ccnt;
    logic [IW-1:0] sbidx;
    logic [IW-1:0] dbidx;
    logic [IW-1:0] scidx;
    logic [IW-1:0] dcidx;
    logic [LW-1:0] link;
    logic          absync;
    logic          sconst;
    logic          dconst;
    logic          chain;
  } pset_t;
endpackage

// File: rtl/dma3d_pset_mem.sv
module dma3d_pset_mem
  import dma3d_pkg::*;
#(
  parameter int NSETS = 4,
  localparam int SLOTW = $clog2(NSETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SLOTW-1:0] waddr,
  input  pset_t            wdata,
  input  logic [LW-1:0]    raddr,
  output pset_t            rdata,
  output logic             rok
);
  pset_t slot_q [NSETS];

  for (genvar g = 0; g < NSETS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         slot_q[g] <= '0;
      else if (we && waddr == SLOTW'(g))  slot_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    rok   = 1'b0;
    for (int i = 0; i < NSETS; i++) begin
      if (raddr == LW'(i)) begin
        rdata = slot_q[i];
        rok   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma3d_addr_step.sv
module dma3d_addr_step
  import dma3d_pkg::*;
(
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] bidx,
  input  logic [IW-1:0] cidx,
  input  logic          cst,
  input  logic          frame_end,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] nxt_base
);
  logic [AW-1:0] bext, cext;
  assign bext = {{(AW-IW){bidx[IW-1]}}, bidx};
  assign cext = {{(AW-IW){cidx[IW-1]}}, cidx};

  always_comb begin
    nxt      = cur;
    nxt_base = base;
    if (!cst) begin
      if (frame_end) begin
        nxt_base = base + cext;
        nxt      = base + cext;
      end else begin
        nxt = cur + bext;
      end
    end
  end
endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
  import dma3d_pkg::*;
#(
  parameter int NSETS = 4,
  localparam int SLOTW = $clog2(NSETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_active,
  input  logic [SLOTW-1:0] cfg_slot,
  input  logic [31:0]      cfg_src,
  input  logic [31:0]      cfg_dst,
  input  logic [15:0]      cfg_acnt,
  input  logic [15:0]      cfg_bcnt,
  input  logic [15:0]      cfg_ccnt,
  input  logic [15:0]      cfg_sbidx,
  input  logic [15:0]      cfg_dbidx,
  input  logic [15:0]      cfg_scidx,
  input  logic [15:0]      cfg_dcidx,
  input  logic [2:0]       cfg_link,
  input  logic             cfg_absync,
  input  logic             cfg_sconst,
  input  logic             cfg_dconst,
  input  logic             cfg_chain,
  input  logic             evt_i,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [31:0]      req_src,
  output logic [31:0]      req_dst,
  output logic [15:0]      req_bytes,
  output logic             done_o,
  output logic             chain_o,
  output logic             err_o
);
  pset_t         cfg_set, act_q, link_set;
  logic          link_ok;
  logic [AW-1:0] src_q, dst_q, fsrc_q, fdst_q;
  logic [AW-1:0] src_nx, dst_nx, fsrc_nx, fdst_nx;
  logic [CW-1:0] bleft_q, cleft_q;
  logic          live_q, busy_q;
  logic          hs, frame_end, blk_end, bad_cfg;

  always_comb begin
    cfg_set        = '0;
    cfg_set.src    = cfg_src;
    cfg_set.dst    = cfg_dst;
    cfg_set.acnt   = cfg_acnt;
    cfg_set.bcnt   = cfg_bcnt;
    cfg_set.ccnt   = cfg_ccnt;
    cfg_set.sbidx  = cfg_sbidx;
    cfg_set.dbidx  = cfg_dbidx;
    cfg_set.scidx  = cfg_scidx;
    cfg_set.dcidx  = cfg_dcidx;
    cfg_set.link   = cfg_link;
    cfg_set.absync = cfg_absync;
    cfg_set.sconst = cfg_sconst;
    cfg_set.dconst = cfg_dconst;
    cfg_set.chain  = cfg_chain;
  end

  dma3d_pset_mem #(.NSETS(NSETS)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we && !cfg_active),
    .waddr (cfg_slot),
    .wdata (cfg_set),
    .raddr (act_q.link),
    .rdata (link_set),
    .rok   (link_ok)
  );

  assign hs        = busy_q && req_ready;
  assign frame_end = (bleft_q == CW'(1));
  assign blk_end   = frame_end && (cleft_q == CW'(1));
  assign bad_cfg   = !live_q || (act_q.acnt == '0) || (act_q.bcnt == '0) || (act_q.ccnt == '0);

  dma3d_addr_step u_src_step (
    .cur       (src_q),
    .base      (fsrc_q),
    .bidx      (act_q.sbidx),
    .cidx      (act_q.scidx),
    .cst       (act_q.sconst),
    .frame_end (frame_end),
    .nxt       (src_nx),
    .nxt_base  (fsrc_nx)
  );

  dma3d_addr_step u_dst_step (
    .cur       (dst_q),
    .base      (fdst_q),
    .bidx      (act_q.dbidx),
    .cidx      (act_q.dcidx),
    .cst       (act_q.dconst),
    .frame_end (frame_end),
    .nxt       (dst_nx),
    .nxt_base  (fdst_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      fsrc_q  <= '0;
      fdst_q  <= '0;
      bleft_q <= '0;
      cleft_q <= '0;
      live_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_o  <= 1'b0;
      chain_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      chain_o <= 1'b0;
      err_o   <= 1'b0;
      if (cfg_we && cfg_active) begin
        act_q   <= cfg_set;
        src_q   <= cfg_set.src;
        dst_q   <= cfg_set.dst;
        fsrc_q  <= cfg_set.src;
        fdst_q  <= cfg_set.dst;
        bleft_q <= cfg_set.bcnt;
        cleft_q <= cfg_set.ccnt;
        live_q  <= 1'b1;
        busy_q  <= 1'b0;
      end else if (hs) begin
        if (blk_end) begin
          done_o  <= 1'b1;
          chain_o <= act_q.chain;
          busy_q  <= 1'b0;
          live_q  <= link_ok;
          if (link_ok) begin
            act_q   <= link_set;
            src_q   <= link_set.src;
            dst_q   <= link_set.dst;
            fsrc_q  <= link_set.src;
            fdst_q  <= link_set.dst;
            bleft_q <= link_set.bcnt;
            cleft_q <= link_set.ccnt;
          end
        end else if (frame_end) begin
          src_q   <= src_nx;
          dst_q   <= dst_nx;
          fsrc_q  <= fsrc_nx;
          fdst_q  <= fdst_nx;
          bleft_q <= act_q.bcnt;
          cleft_q <= cleft_q - CW'(1);
          busy_q  <= 1'b0;
        end else begin
          src_q   <= src_nx;
          dst_q   <= dst_nx;
          bleft_q <= bleft_q - CW'(1);
          busy_q  <= act_q.absync;
        end
      end else if (evt_i && !busy_q) begin
        if (bad_cfg) err_o  <= 1'b1;
        else         busy_q <= 1'b1;
      end
    end
  end

  assign req_valid = busy_q;
  assign req_src   = src_q;
  assign req_dst   = dst_q;
  assign req_bytes = act_q.acnt;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !cfg_we) |=> (req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_bytes))); // R7
  AST_ARRAY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !act_q.absync && !cfg_we) |=> !req_valid); // R2
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(req_valid && req_ready)); // R8
  AST_CHAIN_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    chain_o |-> done_o); // R8
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !req_valid); // R11
endmodule

// File: tb/sim_dma3d_seq.sv
module sim_dma3d_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_active = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_acnt = '0, cfg_bcnt = '0, cfg_ccnt = '0;
  logic [15:0] cfg_sbidx = '0, cfg_dbidx = '0, cfg_scidx = '0, cfg_dcidx = '0;
  logic [2:0]  cfg_link = '0;
  logic        cfg_absync = 1'b0, cfg_sconst = 1'b0, cfg_dconst = 1'b0, cfg_chain = 1'b0;
  logic        evt_i = 1'b0, req_ready = 1'b0;
  logic        req_valid, done_o, chain_o, err_o;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_bytes;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  dma3d_seq u0 (.*);

  // {event before, block end, chain, src, dst, bytes}
  localparam logic [82:0] TBL [10] = '{
    {1'b1, 1'b0, 1'b0, 32'h1000, 32'h2000, 16'd4},
    {1'b1, 1'b0, 1'b0, 32'h1010, 32'h2020, 16'd4},
    {1'b1, 1'b0, 1'b0, 32'h1020, 32'h2040, 16'd4},
    {1'b1, 1'b0, 1'b0, 32'h1100, 32'h1FC0, 16'd4},
    {1'b1, 1'b0, 1'b0, 32'h1110, 32'h1FE0, 16'd4},
    {1'b1, 1'b1, 1'b0, 32'h1120, 32'h2000, 16'd4},
    {1'b1, 1'b0, 1'b0, 32'h5000, 32'h6000, 16'd8},
    {1'b0, 1'b0, 1'b0, 32'h5000, 32'h6010, 16'd8},
    {1'b1, 1'b0, 1'b0, 32'h5000, 32'h6100, 16'd8},
    {1'b0, 1'b1, 1'b1, 32'h5000, 32'h6110, 16'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prog(input logic act, input logic [1:0] slot,
                      input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                      input logic [15:0] sb, input logic [15:0] db,
                      input logic [15:0] sc, input logic [15:0] dc,
                      input logic [2:0] lnk, input logic ab, input logic scs,
                      input logic dcs, input logic chn);
    @(negedge clk);
    cfg_we = 1'b1; cfg_active = act; cfg_slot = slot;
    cfg_src = s; cfg_dst = d; cfg_acnt = a; cfg_bcnt = b; cfg_ccnt = c;
    cfg_sbidx = sb; cfg_dbidx = db; cfg_scidx = sc; cfg_dcidx = dc;
    cfg_link = lnk; cfg_absync = ab; cfg_sconst = scs; cfg_dconst = dcs; cfg_chain = chn;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_evt();
    evt_i = 1'b1;
    @(negedge clk);
    evt_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 valid", 32'(req_valid), 32'd0);
    chk("R1 pulses", {29'd0, done_o, chain_o, err_o}, 32'd0);
    rst_n = 1'b1;

    // slot 1: frame mode, constant source, null link, chain set
    prog(1'b0, 2'd1, 32'h5000, 32'h6000, 16'd8, 16'd2, 16'd2,
         16'h0004, 16'h0010, 16'h0008, 16'h0100, 3'h7, 1'b1, 1'b1, 1'b0, 1'b1);
    // working set: array mode, negative destination frame stride, link to slot 1
    prog(1'b1, 2'd0, 32'h1000, 32'h2000, 16'd4, 16'd3, 16'd2,
         16'h0010, 16'h0020, 16'h0100, 16'hFFC0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    req_ready = 1'b1;

    // R2 R3 R4 R5 R6 R8 R9: walk the expected descriptor table
    for (int i = 0; i < 10; i++) begin
      if (TBL[i][82]) pulse_evt();
      chk("R2/R4 valid", 32'(req_valid), 32'd1);
      chk("R3/R5/R9 src", req_src, TBL[i][79:48]);
      chk("R3/R6/R9 dst", req_dst, TBL[i][47:16]);
      chk("R4 bytes", 32'(req_bytes), 32'(TBL[i][15:0]));
      @(negedge clk);
      chk("R8 done", 32'(done_o), 32'(TBL[i][81]));
      chk("R8 chain", 32'(chain_o), 32'(TBL[i][80]));
      if (TBL[i][81]) chk("R2/R4 idle after block", 32'(req_valid), 32'd0);
    end

    // R10: null link left the sequencer empty
    pulse_evt();
    chk("R10 err", 32'(err_o), 32'd1);
    chk("R10 no request", 32'(req_valid), 32'd0);

    // R7 R12: back-pressure and an event during a stall
    req_ready = 1'b0;
    prog(1'b1, 2'd0, 32'h0100, 32'h0200, 16'd2, 16'd2, 16'd1,
         16'h0004, 16'h0008, 16'h0000, 16'h0000, 3'h7, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_evt();
    chk("R7 valid", 32'(req_valid), 32'd1);
    pulse_evt();
    @(negedge clk);
    chk("R7 stall valid", 32'(req_valid), 32'd1);
    chk("R7 stall src", req_src, 32'h0100);
    chk("R7 stall dst", req_dst, 32'h0200);
    req_ready = 1'b1;
    @(negedge clk);
    chk("R12 ignored event", 32'(req_valid), 32'd0);
    chk("R8 no early done", 32'(done_o), 32'd0);
    pulse_evt();
    chk("R2/R7 one advance src", req_src, 32'h0104);
    chk("R2/R7 one advance dst", req_dst, 32'h0208);
    @(negedge clk);
    chk("R8 done after last", 32'(done_o), 32'd1);
    chk("R8 no chain", 32'(chain_o), 32'd0);

    // R11: zero frame count rejected
    prog(1'b1, 2'd0, 32'h0300, 32'h0400, 16'd4, 16'd1, 16'd0,
         16'h0000, 16'h0000, 16'h0000, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_evt();
    chk("R11 err", 32'(err_o), 32'd1);
    chk("R11 no request", 32'(req_valid), 32'd0);
    @(negedge clk);
    chk("R11 err one cycle", 32'(err_o), 32'd0);

    finish_run();
  end
endmodule